// File: doc/BRIEF.md
# Receive Delay-Line Calibration and Sampling-Phase Tuner

This block sets up a programmable delay line on the receive clock of a card interface. After one start pulse it needs no further help. First it searches for a unit delay code. For each code it puts the line into measuring mode and reads back the measured period length. It keeps the first code whose length falls inside the usable window. The highest set bit of that length gives the number of phase taps that can be used.

Next it steps through those taps in ascending order. At each tap it issues one tuning request to the card interface and notes whether the request passed. It then loads the tap at the centre of the longest unbroken run of passes. It reports the chosen unit code and tap, and it raises an error flag when either search finds nothing.

A step that never receives a valid length is abandoned after a cycle-count timeout. Every rewrite of the delay configuration is followed by a fixed settle time before the block relies on the line.

Top module: `dly_tune_ctrl`

## Requirements
- R1: After synchronous reset the following outputs are all 0: `dl_en`, `dl_smp_en`, `dl_unit`, `dl_sel`, `tune_req`, `done`, `err`, `res_unit` and `res_phase`.
- R2: While a unit code is being measured, `dl_en`=1, `dl_smp_en`=1 and `dl_sel`=NCELLS+1 (12 by default).
- R3: Unit codes are tried in ascending order from 0. The first code whose reported `dl_len` is nonzero and below 2^NCELLS (2048) is kept and appears on `res_unit`. A length of 0 or of 2048 and above rejects that code.
- R4: A code whose `dl_len_vld` does not rise within TIMEOUT_CYC cycles after the settle time is skipped, and the search moves to the next code.
- R5: The last tap of the sweep is the bit index of the most significant 1 in the accepted length. Taps 0 up to that index each receive exactly one `tune_req`, in ascending order, and only one request is outstanding at a time.
- R6: During the tap sweep `dl_en`=1 and `dl_smp_en`=0 whenever `tune_req` is high.
- R7: The final tap is the last tap of the longest passing run minus floor(run length / 2). Of two runs of equal length, the earlier one wins. The final tap is driven on `dl_sel` and on `res_phase`, with `dl_en`=1 and `dl_smp_en`=0.
- R8: If no tap passes, `err`=1 and `done`=1, and the line returns to bypass (`dl_en`=0, `dl_smp_en`=0).
- R9: If no code from 0 to 2^UNIT_W−1 qualifies, `err`=1 and `done`=1, and the line is in bypass.
- R10: `tune_req` is a single-cycle pulse. It is issued only once `dl_sel` has been stable for at least SETTLE_CYC cycles after the tap was loaded.
- R11: A `start` pulse that arrives while a run is in progress has no effect on that run's results.
- R12: A `start` pulse accepted while idle clears `done` and `err` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration and tuning run (single-cycle pulse) |
| dl_en | output | 1 | Delay line enable; 0 selects clock bypass |
| dl_smp_en | output | 1 | Length-measurement sampler enable |
| dl_unit | output | UNIT_W | Unit delay code applied to the line |
| dl_sel | output | SEL_W | Phase tap select applied to the line |
| dl_len | input | LEN_W | Measured period length from the line |
| dl_len_vld | input | 1 | Measured length is valid |
| tune_req | output | 1 | Tuning request pulse to the card interface |
| tune_ack | input | 1 | Tuning request answered (single-cycle pulse) |
| tune_pass | input | 1 | Result of the answered request, valid with `tune_ack` |
| done | output | 1 | Run finished; held until the next start |
| err | output | 1 | Run failed; valid while `done` is high |
| res_unit | output | UNIT_W | Chosen unit delay code |
| res_phase | output | SEL_W | Chosen phase tap |

## Verification
The assertions check the cycle-local rules on every clock:
- calibration always runs with the sampler on and the fixed measuring tap;
- a request is a one-cycle pulse, issued with the sampler off, with a stable tap that stays within the sweep bound;
- an error never appears without `done`, and a failure leaves the line in bypass;
- the stored best run never falls below the current run;
- the timeout and settle counters count down by one.

Only the bench scenarios can show the search results. These include which unit code wins when earlier codes report zero, report an oversized length or time out, and the exact order of taps swept. They also include the centring arithmetic for odd runs, even runs and tied runs, the two failure paths, and that a stray start during a run changes nothing.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAL_SET,
    ST_CAL_HOLD,
    ST_CAL_WAIT,
    ST_CAL_NEXT,
    ST_PH_SET,
    ST_PH_HOLD,
    ST_PH_WAIT,
    ST_APPLY,
    ST_FAIL
  } dlt_state_e;
endpackage

// File: rtl/dlt_timer.sv
module dlt_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= value;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_timer_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dlt_msb.sv
module dlt_msb #(
  parameter int LEN_W = 12,
  parameter int IDX_W = 4
) (
  input  logic [LEN_W-1:0] val,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < LEN_W; i++) begin
      if (val[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dlt_window.sv
module dlt_window #(
  parameter int PH_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          upd,
  input  logic          pass,
  input  logic [PH_W-1:0] phase,
  output logic [PH_W:0]   best_len,
  output logic [PH_W-1:0] best_end
);
  logic [PH_W:0] cur_len;
  logic [PH_W:0] cur_nxt;

  assign cur_nxt = cur_len + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cur_len  <= '0;
      best_len <= '0;
      best_end <= '0;
    end else if (upd) begin
      if (pass) begin
        cur_len <= cur_nxt;
        if (cur_nxt > best_len) begin
          best_len <= cur_nxt;
          best_end <= phase;
        end
      end else begin
        cur_len <= '0;
      end
    end
  end

  p_best_ge_cur_r7: assert property (@(posedge clk) disable iff (rst)
    best_len >= cur_len);
endmodule

// File: rtl/dly_tune_ctrl.sv
module dly_tune_ctrl
  import dlt_pkg::*;
#(
  parameter int UNIT_W      = 7,
  parameter int SEL_W       = 4,
  parameter int LEN_W       = 12,
  parameter int NCELLS      = 11,
  parameter int TIMEOUT_CYC = 250000,
  parameter int SETTLE_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              dl_en,
  output logic              dl_smp_en,
  output logic [UNIT_W-1:0] dl_unit,
  output logic [SEL_W-1:0]  dl_sel,
  input  logic [LEN_W-1:0]  dl_len,
  input  logic              dl_len_vld,
  output logic              tune_req,
  input  logic              tune_ack,
  input  logic              tune_pass,
  output logic              done,
  output logic              err,
  output logic [UNIT_W-1:0] res_unit,
  output logic [SEL_W-1:0]  res_phase
);
  localparam logic [UNIT_W-1:0] UNIT_MAX = {UNIT_W{1'b1}};
  localparam logic [SEL_W-1:0]  CAL_SEL  = SEL_W'(NCELLS + 1);
  localparam int                TMO_W    = $clog2(TIMEOUT_CYC + 1);
  localparam int                SET_W    = $clog2(SETTLE_CYC + 2);
  localparam logic [LEN_W:0]    LEN_LIM  = (LEN_W + 1)'(1) << NCELLS;

  dlt_state_e st;
  logic [UNIT_W-1:0] cal_unit;
  logic [SEL_W-1:0]  ph, max_ph, len_msb, final_ph;
  logic              set_load, set_zero, tmo_load, tmo_zero;
  logic              win_clear, win_upd;
  logic [SEL_W:0]    best_len;
  logic [SEL_W-1:0]  best_end;
  logic              len_ok;

  dlt_timer #(.W(SET_W)) u_settle (
    .clk(clk), .rst(rst), .load(set_load),
    .value(SET_W'(SETTLE_CYC)), .zero(set_zero));

  dlt_timer #(.W(TMO_W)) u_timeout (
    .clk(clk), .rst(rst), .load(tmo_load),
    .value(TMO_W'(TIMEOUT_CYC)), .zero(tmo_zero));

  dlt_msb #(.LEN_W(LEN_W), .IDX_W(SEL_W)) u_msb (
    .val(dl_len), .idx(len_msb));

  dlt_window #(.PH_W(SEL_W)) u_win (
    .clk(clk), .rst(rst), .clear(win_clear), .upd(win_upd),
    .pass(tune_pass), .phase(ph),
    .best_len(best_len), .best_end(best_end));

  assign len_ok    = (dl_len != '0) && ({1'b0, dl_len} < LEN_LIM);
  assign set_load  = (st == ST_CAL_SET) || (st == ST_PH_SET);
  assign tmo_load  = (st == ST_CAL_HOLD) && set_zero;
  assign win_clear = (st == ST_IDLE) && start;
  assign win_upd   = (st == ST_PH_WAIT) && tune_ack;
  assign final_ph  = best_end - SEL_W'(best_len >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cal_unit  <= '0;
      ph        <= '0;
      max_ph    <= '0;
      dl_en     <= 1'b0;
      dl_smp_en <= 1'b0;
      dl_unit   <= '0;
      dl_sel    <= '0;
      tune_req  <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      res_unit  <= '0;
      res_phase <= '0;
    end else begin
      tune_req <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            done     <= 1'b0;
            err      <= 1'b0;
            cal_unit <= '0;
            st       <= ST_CAL_SET;
          end
        end
        ST_CAL_SET: begin
          dl_en     <= 1'b1;
          dl_smp_en <= 1'b1;
          dl_unit   <= cal_unit;
          dl_sel    <= CAL_SEL;
          st        <= ST_CAL_HOLD;
        end
        ST_CAL_HOLD: begin
          if (set_zero) st <= ST_CAL_WAIT;
        end
        ST_CAL_WAIT: begin
          if (dl_len_vld) begin
            if (len_ok) begin
              res_unit <= cal_unit;
              max_ph   <= len_msb;
              ph       <= '0;
              st       <= ST_PH_SET;
            end else begin
              st <= ST_CAL_NEXT;
            end
          end else if (tmo_zero) begin
            st <= ST_CAL_NEXT;
          end
        end
        ST_CAL_NEXT: begin
          if (cal_unit == UNIT_MAX) begin
            st <= ST_FAIL;
          end else begin
            cal_unit <= cal_unit + 1'b1;
            st       <= ST_CAL_SET;
          end
        end
        ST_PH_SET: begin
          dl_en     <= 1'b1;
          dl_smp_en <= 1'b0;
          dl_sel    <= ph;
          st        <= ST_PH_HOLD;
        end
        ST_PH_HOLD: begin
          if (set_zero) begin
            tune_req <= 1'b1;
            st       <= ST_PH_WAIT;
          end
        end
        ST_PH_WAIT: begin
          if (tune_ack) begin
            if (ph == max_ph) begin
              st <= ST_APPLY;
            end else begin
              ph <= ph + 1'b1;
              st <= ST_PH_SET;
            end
          end
        end
        ST_APPLY: begin
          if (best_len == '0) begin
            st <= ST_FAIL;
          end else begin
            dl_sel    <= final_ph;
            res_phase <= final_ph;
            done      <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_FAIL: begin
          dl_en     <= 1'b0;
          dl_smp_en <= 1'b0;
          dl_sel    <= '0;
          res_phase <= '0;
          err       <= 1'b1;
          done      <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    tune_req |=> !tune_req);
  p_req_stable_r10: assert property (@(posedge clk) disable iff (rst)
    tune_req |-> $stable(dl_sel));
  p_sweep_cfg_r6: assert property (@(posedge clk) disable iff (rst)
    tune_req |-> (dl_en && !dl_smp_en));
  p_cal_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    dl_smp_en |-> (dl_en && dl_sel == CAL_SEL));
  p_tap_bound_r5: assert property (@(posedge clk) disable iff (rst)
    tune_req |-> (dl_sel <= max_ph));
  p_err_done_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  p_fail_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (!dl_en && !dl_smp_en));
endmodule

// File: tb/dly_tune_ctrl_bench.sv
`timescale 1ns/1ps
module dly_tune_ctrl_bench;
  localparam int TMO = 40;
  localparam int SET = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, start;
  logic dl_en, dl_smp_en, tune_req, done, err;
  logic [6:0] dl_unit, res_unit;
  logic [3:0] dl_sel, res_phase;
  logic [11:0] dl_len;
  logic dl_len_vld, tune_ack, tune_pass;

  dly_tune_ctrl #(.TIMEOUT_CYC(TMO), .SETTLE_CYC(SET)) u_dly_tune_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .dl_en(dl_en), .dl_smp_en(dl_smp_en), .dl_unit(dl_unit), .dl_sel(dl_sel),
    .dl_len(dl_len), .dl_len_vld(dl_len_vld),
    .tune_req(tune_req), .tune_ack(tune_ack), .tune_pass(tune_pass),
    .done(done), .err(err), .res_unit(res_unit), .res_phase(res_phase));

  int checks = 0, failures = 0, cyc = 0;
  int len_tab [128];   // -1: line never reports a valid length
  logic [15:0] pass_mask;

  typedef struct { bit e; int unit; int phase; string tag; } res_t;
  int   exp_ph_q  [$];
  res_t exp_res_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // delay line model: valid length after the unit code has been steady
  int stab = 0;
  logic [6:0] last_unit = '0;
  always @(negedge clk) begin
    if (rst || !(dl_en && dl_smp_en)) begin
      dl_len_vld <= 1'b0; dl_len <= '0; stab <= 0;
    end else begin
      last_unit <= dl_unit;
      if (dl_unit != last_unit) begin
        stab <= 0; dl_len_vld <= 1'b0;
      end else begin
        stab <= stab + 1;
        if (stab >= 2 && len_tab[dl_unit] >= 0) begin
          dl_len_vld <= 1'b1; dl_len <= 12'(len_tab[dl_unit]);
        end else dl_len_vld <= 1'b0;
      end
    end
  end

  // card model: answers each request two cycles later
  int pend = 0;
  always @(negedge clk) begin
    tune_ack <= 1'b0;
    if (rst) begin pend <= 0; tune_pass <= 1'b0; end
    else if (tune_req) pend <= 2;
    else if (pend == 1) begin
      tune_ack <= 1'b1; tune_pass <= pass_mask[dl_sel]; pend <= 0;
    end else if (pend > 1) pend <= pend - 1;
  end

  // monitor
  logic done_q = 1'b0, smp_q = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (dl_smp_en && !smp_q)
        check(dl_en && dl_sel == 4'd12, "R2", "calibration tap", int'(dl_sel), 12);
      if (tune_req) begin
        check(dl_en && !dl_smp_en, "R6", "sampler during sweep", int'(dl_smp_en), 0);
        if (exp_ph_q.size() == 0) check(0, "R5", "unexpected request tap", int'(dl_sel), -1);
        else begin
          int e; e = exp_ph_q.pop_front();
          check(int'(dl_sel) == e, "R5", "request tap", int'(dl_sel), e);
        end
      end
      if (done && !done_q) begin
        check(exp_ph_q.size() == 0, "R5", "requests left over", exp_ph_q.size(), 0);
        exp_ph_q.delete();
        if (exp_res_q.size() == 0) check(0, "R7", "unexpected done", 1, 0);
        else begin
          res_t r; r = exp_res_q.pop_front();
          check(err == r.e, r.tag, "err", int'(err), int'(r.e));
          if (r.unit >= 0)
            check(int'(res_unit) == r.unit, "R3", "res_unit", int'(res_unit), r.unit);
          if (r.e) check(!dl_en && !dl_smp_en, r.tag, "bypass", int'(dl_en), 0);
          else begin
            check(int'(res_phase) == r.phase, "R7", "res_phase", int'(res_phase), r.phase);
            check(int'(dl_sel) == r.phase && dl_en && !dl_smp_en, "R7", "applied tap",
                  int'(dl_sel), r.phase);
          end
        end
      end
    end
    done_q <= done;
    smp_q  <= dl_smp_en;
  end

  // watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "WDOG", "watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  // driver: predicts the outcome from the requirements, then runs
  task automatic run_scn(input string tag, input int stray_at);
    int u, mx, cur, best, last;
    u = -1;
    for (int i = 0; i < 128; i++)
      if (u < 0 && len_tab[i] > 0 && len_tab[i] < 2048) u = i;
    if (u < 0) exp_res_q.push_back('{1'b1, -1, 0, "R9"});
    else begin
      mx = 0;
      for (int b = 0; b < 12; b++) if (len_tab[u][b]) mx = b;
      cur = 0; best = 0; last = 0;
      for (int p = 0; p <= mx; p++) begin
        exp_ph_q.push_back(p);
        if (pass_mask[p]) begin
          cur++;
          if (cur > best) begin best = cur; last = p; end
        end else cur = 0;
      end
      if (best == 0) exp_res_q.push_back('{1'b1, u, 0, "R8"});
      else exp_res_q.push_back('{1'b0, u, last - best / 2, tag});
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && !err, "R12", "done/err cleared by start", int'(done), 0);
    for (int k = 0; !done; k++) begin
      if (k == stray_at) start = 1'b1;   // R11 stray start mid-run
      @(negedge clk);
      start = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; pass_mask = '0;
    for (int i = 0; i < 128; i++) len_tab[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!dl_en && !dl_smp_en && !tune_req, "R1", "line controls", int'(dl_en), 0);
    check(!done && !err, "R1", "done/err", int'(done), 0);
    check(dl_unit == 0 && dl_sel == 0, "R1", "unit/tap", int'(dl_sel), 0);
    check(res_unit == 0 && res_phase == 0, "R1", "results", int'(res_phase), 0);

    // S1: zero length, timeout (R4), oversized length (R3), then accept 416 -> max tap 8
    len_tab[0] = 0; len_tab[1] = -1; len_tab[2] = 3000; len_tab[3] = 416;
    pass_mask = 16'b0000_0001_0111_1100;
    run_scn("R7", -1);

    // S2: tie between two runs of two, earliest wins; length 2047 -> max tap 10
    for (int i = 0; i < 128; i++) len_tab[i] = 0;
    len_tab[0] = 2047;
    pass_mask = 16'b0000_0100_0011_0011;
    run_scn("R7", -1);

    // S3: single tap sweep that fails (R8)
    for (int i = 0; i < 128; i++) len_tab[i] = 0;
    len_tab[5] = 1;
    pass_mask = '0;
    run_scn("R8", -1);

    // S4: no unit code qualifies (R9)
    for (int i = 0; i < 128; i++) len_tab[i] = (i % 3 == 0) ? 4095 : 0;
    run_scn("R9", -1);

    // S5: even run of four, stray start mid-run ignored (R11)
    for (int i = 0; i < 128; i++) len_tab[i] = 0;
    len_tab[0] = 64;
    pass_mask = 16'b0000_0000_0001_1110;
    run_scn("R11", 20);
    check(exp_res_q.size() == 0, "R11", "extra run after stray start", exp_res_q.size(), 0);
    check(!tune_req && done, "R11", "idle after run", int'(tune_req), 0);

    finish_run();
  end
endmodule